// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one memory request issued by a group of 16 threads and turns it into a short series of aligned memory transactions. A request carries an active-thread mask, one byte address per thread, an access-size code and a mode bit. The block accepts the request with a valid/ready handshake and stores it. It then emits transactions one per output handshake. Each transaction gives an aligned base address, a byte count of 32, 64 or 128, and the mask of threads that it serves.

Each round starts from the lowest-numbered thread that has not yet been served. The segment that holds that thread's address collects every other unserved thread whose address lies in the same segment. The segment is then shrunk to the smallest aligned region that still covers all of their addresses. In relaxed mode (mode bit 0) this is the whole algorithm. In strict mode (mode bit 1) a request is merged only if every active thread k addresses word k of one segment. A request that breaks this rule is issued as one 32-byte transaction per active thread, in ascending thread order. A single-cycle done pulse closes each request.

Top module: `hw_coalescer`

## Requirements
- R1: After reset, req_ready is 1, tx_valid is 0 and done is 0.
- R2: req_ready is 1 only while no request is being processed. A request is taken on a cycle where req_valid and req_ready are both 1. req_ready stays 0 while transactions of that request are still pending.
- R3: The access-size code selects the segment. Code 0 (1-byte words) selects 32 bytes, code 1 (2-byte words) selects 64 bytes, and code 2 (4-byte words) selects 128 bytes. Code 3 is treated as code 2. tx_base is always aligned to tx_bytes.
- R4: Each transaction is led by the lowest-numbered active thread that is still unserved. Every other unserved thread whose address is in the leader's segment joins that transaction. Transactions therefore leave in ascending order of their leading thread.
- R5: A 128-byte segment becomes 64 bytes when all member addresses share address bit 6. A 64-byte segment becomes 32 bytes when all member addresses share address bit 5. The result is never below 32 bytes. Addresses are assumed aligned to the access size.
- R6: Threads served by a transaction are removed from the request. Every active thread appears in exactly one transaction, and inactive threads appear in none.
- R7: In strict mode, if every active thread k holds the address S + k·w, the request is coalesced exactly as in relaxed mode. Here S is the segment base of the lowest active thread and w is the word size in bytes.
- R8: In strict mode, a request that breaks the R7 rule is issued as one 32-byte transaction per active thread, in ascending thread order. Each has a one-hot mask and the thread address aligned down to 32.
- R9: While tx_valid is 1 and tx_ready is 0, tx_base, tx_bytes and tx_mask hold their values and tx_valid stays 1.
- R10: A request with an all-zero active mask issues no transaction. done is 1 in the cycle after acceptance.
- R11: done is 1 for exactly one cycle, in the cycle after the handshake of the request's last transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_mask | input | 16 | Active-thread mask, bit k for thread k |
| req_addr | input | 512 | Byte addresses, thread k in bits [32k+31:32k] |
| req_size | input | 2 | Access-size code (0: 1 B, 1: 2 B, 2: 4 B) |
| req_strict | input | 1 | 1 selects strict sequential mode |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_base | output | 32 | Aligned transaction base address |
| tx_bytes | output | 8 | Transaction size: 32, 64 or 128 |
| tx_mask | output | 16 | Threads served by this transaction |
| done | output | 1 | One-cycle pulse ending a request |

## Verification
A request accepted at clock edge n produces its first transaction combinationally from the state registered at edge n, so tx_valid is high from just after that edge. Each later transaction follows one cycle after the previous handshake. done rises one edge after the final handshake, or one edge after acceptance for an empty mask. The bench drives every input on the falling edge and reads every output on the following falling edge. It records transactions only on cycles where it drove tx_ready high. It checks that done appears exactly one cycle after the last recorded handshake and is gone one cycle later. Stall runs hold tx_ready low on alternate cycles and compare the held outputs across the stalled cycle.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic [1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } hwc_state_e;

    localparam int MIN_LG = 5;

    // log2 of the segment size for an access-size code
    function automatic logic [2:0] seg_lg(acc_e acc);
        case (acc)
            ACC_B1:  return 3'd5;
            ACC_B2:  return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/hwc_strict_chk.sv
module hwc_strict_chk
    import hwc_pkg::*;
#(
    parameter int NTHREADS = 16,
    parameter int AW       = 32
) (
    input  logic [NTHREADS-1:0]    mask,
    input  logic [NTHREADS*AW-1:0] addr,
    input  acc_e                   acc,
    output logic                   seq_ok
);
    always_comb begin
        logic [AW-1:0] lead_addr;
        logic [AW-1:0] seg_base;
        logic [2:0]    lg;
        lead_addr = '0;
        for (int k = NTHREADS - 1; k >= 0; k--) begin
            if (mask[k]) lead_addr = addr[k*AW +: AW];
        end
        lg       = seg_lg(acc);
        seg_base = lead_addr & ~((AW'(1) << lg) - AW'(1));
        seq_ok   = 1'b1;
        for (int k = 0; k < NTHREADS; k++) begin
            if (mask[k] &&
                addr[k*AW +: AW] != seg_base + (AW'(k) << (lg - 3'(MIN_LG))))
                seq_ok = 1'b0;
        end
    end
endmodule

// File: rtl/hwc_former.sv
module hwc_former
    import hwc_pkg::*;
#(
    parameter int NTHREADS = 16,
    parameter int AW       = 32
) (
    input  logic [NTHREADS-1:0]    pending,
    input  logic [NTHREADS*AW-1:0] addr,
    input  acc_e                   acc,
    input  logic                   single,
    output logic [AW-1:0]          t_base,
    output logic [2:0]             t_lg,
    output logic [NTHREADS-1:0]    t_mask
);
    always_comb begin
        logic [AW-1:0] lead_addr;
        logic [AW-1:0] hi_mask;
        logic [2:0]    lg;
        logic          b6_one, b6_zero, b5_one, b5_zero;
        int            lead;
        lead      = 0;
        lead_addr = '0;
        for (int k = NTHREADS - 1; k >= 0; k--) begin
            if (pending[k]) begin
                lead      = k;
                lead_addr = addr[k*AW +: AW];
            end
        end
        lg      = single ? 3'(MIN_LG) : seg_lg(acc);
        hi_mask = ~((AW'(1) << lg) - AW'(1));
        t_mask  = '0;
        for (int k = 0; k < NTHREADS; k++) begin
            if (single)
                t_mask[k] = pending[k] && (k == lead);
            else
                t_mask[k] = pending[k] &&
                            (((addr[k*AW +: AW] ^ lead_addr) & hi_mask) == '0);
        end
        b6_one = 1'b0; b6_zero = 1'b0; b5_one = 1'b0; b5_zero = 1'b0;
        for (int k = 0; k < NTHREADS; k++) begin
            if (t_mask[k]) begin
                if (addr[k*AW + 6]) b6_one = 1'b1; else b6_zero = 1'b1;
                if (addr[k*AW + 5]) b5_one = 1'b1; else b5_zero = 1'b1;
            end
        end
        if (lg == 3'd7 && !(b6_one && b6_zero)) lg = 3'd6;
        if (lg == 3'd6 && !(b5_one && b5_zero)) lg = 3'd5;
        t_lg   = lg;
        t_base = lead_addr & ~((AW'(1) << lg) - AW'(1));
    end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
    import hwc_pkg::*;
#(
    parameter int NTHREADS = 16,
    parameter int AW       = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [NTHREADS-1:0]    req_mask,
    input  logic [NTHREADS*AW-1:0] req_addr,
    input  logic [1:0]             req_size,
    input  logic                   req_strict,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic [AW-1:0]          tx_base,
    output logic [7:0]             tx_bytes,
    output logic [NTHREADS-1:0]    tx_mask,
    output logic                   done
);
    hwc_state_e              state_q;
    logic [NTHREADS-1:0]     pend_q;
    logic [NTHREADS*AW-1:0]  addr_q;
    acc_e                    acc_q;
    logic                    single_q;
    logic                    done_q;
    logic                    seq_ok;
    logic [2:0]              t_lg;
    logic [NTHREADS-1:0]     rest;

    hwc_strict_chk #(.NTHREADS(NTHREADS), .AW(AW)) u_strict (
        .mask   (req_mask),
        .addr   (req_addr),
        .acc    (acc_e'(req_size)),
        .seq_ok (seq_ok)
    );

    hwc_former #(.NTHREADS(NTHREADS), .AW(AW)) u_former (
        .pending (pend_q),
        .addr    (addr_q),
        .acc     (acc_q),
        .single  (single_q),
        .t_base  (tx_base),
        .t_lg    (t_lg),
        .t_mask  (tx_mask)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign tx_valid  = (state_q == ST_BUSY);
    assign tx_bytes  = 8'(1) << t_lg;
    assign done      = done_q;
    assign rest      = pend_q & ~tx_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pend_q   <= '0;
            addr_q   <= '0;
            acc_q    <= ACC_B1;
            single_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (req_valid) begin
                    pend_q   <= req_mask;
                    addr_q   <= req_addr;
                    acc_q    <= acc_e'(req_size);
                    single_q <= req_strict && !seq_ok;
                    if (req_mask == '0) done_q  <= 1'b1;
                    else                state_q <= ST_BUSY;
                end
            end else if (tx_ready) begin
                pend_q <= rest;
                if (rest == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) &&
                                  $stable(tx_bytes) && $stable(tx_mask));
    // R3
    tx_align_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ((tx_base & AW'(tx_bytes - 8'd1)) == '0));
    // R6
    tx_serves_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_mask != '0) && ((tx_mask & ~pend_q) == '0));
    // R8
    fallback_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && single_q |-> $countones(tx_mask) == 1 && tx_bytes == 8'd32);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && tx_valid));
endmodule

// File: tb/hw_coalescer_bench.sv
module hw_coalescer_bench;
    localparam int NT = 16;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [NT-1:0]   req_mask = '0;
    logic [NT*AW-1:0] req_addr = '0;
    logic [1:0]      req_size = 2'd0;
    logic            req_strict = 1'b0;
    logic            tx_valid;
    logic            tx_ready = 1'b0;
    logic [AW-1:0]   tx_base;
    logic [7:0]      tx_bytes;
    logic [NT-1:0]   tx_mask;
    logic            done;

    always #2 clk = ~clk;

    hw_coalescer u_hw_coalescer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .req_size(req_size),
        .req_strict(req_strict), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_base(tx_base), .tx_bytes(tx_bytes), .tx_mask(tx_mask), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [AW-1:0] a [NT];
    logic [AW-1:0] gb [NT];
    logic [7:0]    gs [NT];
    logic [NT-1:0] gm [NT];
    int            gn;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [NT-1:0] m, input logic [1:0] sz,
                           input bit strict, input bit stall);
        int cyc, last_hs, done_at, busy_rdy;
        bit held;
        logic [AW-1:0] hb; logic [7:0] hs; logic [NT-1:0] hm;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", AW'(req_ready), 1);
        for (int k = 0; k < NT; k++) req_addr[k*AW +: AW] = a[k];
        req_mask = m; req_size = sz; req_strict = strict; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; last_hs = -1; done_at = -1; gn = 0; busy_rdy = 0; held = 1'b0;
        hb = '0; hs = '0; hm = '0;
        while (done_at < 0 && cyc < 200) begin
            if (done) done_at = cyc;
            else begin
                if (held) begin
                    chk(tx_valid && tx_base == hb && tx_bytes == hs && tx_mask == hm,
                        "R9", "held transaction", tx_base, hb);
                    held = 1'b0;
                end
                tx_ready = stall ? cyc[0] : 1'b1;
                if (tx_valid && req_ready) busy_rdy++;
                if (tx_valid && tx_ready && gn < NT) begin
                    gb[gn] = tx_base; gs[gn] = tx_bytes; gm[gn] = tx_mask;
                    gn++; last_hs = cyc;
                end else if (tx_valid && !tx_ready) begin
                    held = 1'b1; hb = tx_base; hs = tx_bytes; hm = tx_mask;
                end
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        tx_ready = 1'b0;
        chk(busy_rdy == 0, "R2", "ready while busy", AW'(busy_rdy), 0);
        chk(done_at == last_hs + 1, "R11", "done timing", AW'(done_at), AW'(last_hs + 1));
        chk(done == 1'b0, "R11", "done width", AW'(done), 0);
    endtask

    task automatic exp_n(input int n, input string tag);
        chk(gn == n, tag, "transaction count", AW'(gn), AW'(n));
    endtask

    task automatic exp_tx(input int i, input logic [AW-1:0] b, input logic [7:0] s,
                          input logic [NT-1:0] m, input string tag);
        if (i < gn) begin
            chk(gb[i] == b, tag, $sformatf("tx%0d base", i), gb[i], b);
            chk(gs[i] == s, tag, $sformatf("tx%0d bytes", i), AW'(gs[i]), AW'(s));
            chk(gm[i] == m, tag, $sformatf("tx%0d mask", i), AW'(gm[i]), AW'(m));
        end else chk(1'b0, tag, $sformatf("tx%0d missing", i), AW'(gn), AW'(i + 1));
    endtask

    task automatic clear_addr();
        for (int k = 0; k < NT; k++) a[k] = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready", AW'(req_ready), 1);
        chk(tx_valid == 1'b0, "R1", "tx_valid", AW'(tx_valid), 0);
        chk(done == 1'b0, "R1", "done", AW'(done), 0);
    endtask

    // full 4-byte sequential group: 64 bytes used, 128 segment shrinks to 64
    task automatic t_full_seq();
        for (int k = 0; k < NT; k++) a[k] = 32'h1000 + 32'(4 * k);
        run_req(16'hFFFF, 2'd2, 1'b0, 1'b0);
        exp_n(1, "R5");
        exp_tx(0, 32'h1000, 8'd64, 16'hFFFF, "R5");
    endtask

    // four threads in upper half, low quarter: shrinks to 32
    task automatic t_shrink32();
        clear_addr();
        for (int k = 0; k < 4; k++) a[k] = 32'h2040 + 32'(4 * k);
        run_req(16'h000F, 2'd2, 1'b0, 1'b0);
        exp_n(1, "R5");
        exp_tx(0, 32'h2040, 8'd32, 16'h000F, "R5");
    endtask

    // scattered threads 0, 2, 5
    task automatic t_scatter(input bit stall);
        clear_addr();
        a[0] = 32'h100; a[2] = 32'h300; a[5] = 32'h17C;
        a[1] = 32'h104; // inactive thread in same segment must not join
        run_req(16'h0025, 2'd2, 1'b0, stall);
        exp_n(2, "R6");
        exp_tx(0, 32'h100, 8'd128, 16'h0021, "R4");
        exp_tx(1, 32'h300, 8'd32, 16'h0004, "R4");
    endtask

    task automatic t_empty();
        for (int k = 0; k < NT; k++) a[k] = 32'h40 * k;
        run_req(16'h0000, 2'd2, 1'b0, 1'b0);
        exp_n(0, "R10");
    endtask

    task automatic t_strict_ok2();
        for (int k = 0; k < NT; k++) a[k] = 32'h4000 + 32'(2 * k);
        run_req(16'hFFFF, 2'd1, 1'b1, 1'b0);
        exp_n(1, "R7");
        exp_tx(0, 32'h4000, 8'd32, 16'hFFFF, "R7");
    endtask

    task automatic t_swap(input bit strict);
        clear_addr();
        a[0] = 32'h800; a[1] = 32'h804; a[2] = 32'h80C; a[3] = 32'h808;
        run_req(16'h000F, 2'd2, strict, 1'b0);
        if (strict) begin
            exp_n(4, "R8");
            for (int k = 0; k < 4; k++) exp_tx(k, 32'h800, 8'd32, 16'(1 << k), "R8");
        end else begin
            exp_n(1, "R4");
            exp_tx(0, 32'h800, 8'd32, 16'h000F, "R4");
        end
    endtask

    task automatic t_strict_partial(input bit shifted);
        clear_addr();
        for (int k = 4; k < 8; k++)
            a[k] = 32'h600 + 32'(4 * (shifted ? k - 4 : k));
        run_req(16'h00F0, 2'd2, 1'b1, 1'b1);
        if (!shifted) begin
            exp_n(1, "R7");
            exp_tx(0, 32'h600, 8'd32, 16'h00F0, "R7");
        end else begin
            exp_n(4, "R8");
            for (int k = 4; k < 8; k++) exp_tx(k - 4, 32'h600, 8'd32, 16'(1 << k), "R8");
        end
    endtask

    // byte accesses: 32-byte segments
    task automatic t_bytes();
        clear_addr();
        a[0] = 32'h51; a[1] = 32'h75; a[2] = 32'h5F;
        run_req(16'h0007, 2'd0, 1'b0, 1'b0);
        exp_n(2, "R3");
        exp_tx(0, 32'h40, 8'd32, 16'h0005, "R3");
        exp_tx(1, 32'h60, 8'd32, 16'h0002, "R3");
    endtask

    // code 3 behaves as 4-byte words
    task automatic t_code3();
        clear_addr();
        a[0] = 32'h3000; a[1] = 32'h3070;
        run_req(16'h0003, 2'd3, 1'b0, 1'b0);
        exp_n(1, "R3");
        exp_tx(0, 32'h3000, 8'd128, 16'h0003, "R3");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_seq();
        t_shrink32();
        t_scatter(1'b0);
        t_scatter(1'b1);
        t_empty();
        t_strict_ok2();
        t_swap(1'b1);
        t_swap(1'b0);
        t_strict_partial(1'b0);
        t_strict_partial(1'b1);
        t_bytes();
        t_code3();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule